// File: doc/BRIEF.md
# Tag-Renaming Reservation Station Pool

This block holds a small pool of arithmetic reservation stations, the architectural register file and a per-register producer tag. An instruction enters through the issue port with an opcode, two source register numbers and a destination register number. It is placed in a free station. Each source either takes its value from the register file or, when a station still in flight will produce that register, keeps that station's tag and waits. The destination register then records the new station as its pending producer, which renames it.

A station whose two operands are both present is offered to an external functional unit through a valid/ready execute handshake. That unit later returns the result tagged with the station number. Finished stations compete for a single result bus, and the lowest-numbered one wins. A broadcast writes every register still waiting on that tag, wakes every station operand waiting on it, and frees the producing station. A read port lets the surrounding logic see any register's value and pending tag.

Top module: `resStationPool`

## Requirements
- R1: After reset, register r holds the value r and has pending tag 0, every station is free, issueReady is 1, and execValid and bcastValid are 0.
- R2: An accepted issue takes the lowest-numbered free station. Stations carry tags 1..NUM_ST, where station k has tag k. The station's tag is written into the destination register's pending tag. issueReady is 0 while every station is busy.
- R3: At issue, a source whose register has pending tag 0 takes the register value. A source with a nonzero pending tag keeps that tag and waits.
- R4: execValid is 1 only for a station that has been issued, has not yet been dispatched and has both operands present. The lowest-numbered such station is offered, with execTag, execOp, execOpA (first source) and execOpB (second source). It counts as dispatched on a cycle where execReady is 1.
- R5: A completion (cmplValid with cmplTag) stores cmplValue in that station, which may broadcast from the next cycle.
- R6: While busHold is 0, the lowest-numbered finished station drives bcastValid, bcastTag and bcastValue. Other finished stations wait for a later cycle. Nothing is broadcast while busHold is 1.
- R7: On a broadcast, every register whose pending tag equals bcastTag takes bcastValue and has its tag cleared to 0.
- R8: On a broadcast, every station operand waiting on bcastTag captures bcastValue and stops waiting.
- R9: The broadcasting station is free again from the next cycle.
- R10: If an issuing source's pending tag is being broadcast in the same cycle, the source takes bcastValue directly and does not wait.
- R11: A register re-targeted by a newer producer is not written by the broadcast of an older producer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | Issue request |
| issueReady | output | 1 | A station is free |
| issueOp | input | OP_W | Opcode of issued instruction |
| issueSrcA | input | REG_W | First source register |
| issueSrcB | input | REG_W | Second source register |
| issueDest | input | REG_W | Destination register |
| execValid | output | 1 | A station is offered for execution |
| execReady | input | 1 | Functional unit accepts the offer |
| execTag | output | TAG_W | Tag of offered station |
| execOp | output | OP_W | Opcode of offered station |
| execOpA | output | DATA_W | First operand |
| execOpB | output | DATA_W | Second operand |
| cmplValid | input | 1 | Functional unit returns a result |
| cmplTag | input | TAG_W | Station the result belongs to |
| cmplValue | input | DATA_W | Result value |
| busHold | input | 1 | Result bus is taken this cycle |
| bcastValid | output | 1 | Result bus carries a result |
| bcastTag | output | TAG_W | Producer tag on the bus |
| bcastValue | output | DATA_W | Value on the bus |
| regQueryIdx | input | REG_W | Register to observe |
| regQueryValue | output | DATA_W | Value of observed register |
| regQueryTag | output | TAG_W | Pending tag of observed register |

## Verification
Some properties are checked on every cycle. An accepted issue adds exactly one busy station. A broadcast station is never busy on the next cycle. Dispatch only picks stations whose operands are present. No station operand or register tag still names a tag after that tag has been broadcast, which also covers the same-cycle bypass at issue. The arithmetic flow, the lowest-first grant of the bus, the write-after-write protection of a register, and whether issue really bypasses rather than stalling forever can only be shown by the bench's scenarios. These are a sweep over every opcode and register pair, and a dependency chain run with the bus held.

// File: rtl/rspPkg.sv
package rspPkg;
  typedef struct packed {
    logic issueEn;
    logic dispEn;
    logic bcastEn;
  } rspStrobes_t;
endpackage

// File: rtl/rspControl.sv
module rspControl import rspPkg::*; #(
  parameter int NUM_ST = 4,
  parameter int TAG_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  input  logic [NUM_ST-1:0] opsReady,
  input  logic              execReady,
  input  logic              busHold,
  input  logic              cmplValid,
  input  logic [TAG_W-1:0]  cmplTag,
  output rspStrobes_t       strb,
  output logic [TAG_W-1:0]  issueTag,
  output logic [TAG_W-1:0]  dispTag,
  output logic [TAG_W-1:0]  bcastTag,
  output logic              issueReady,
  output logic              execValid,
  output logic              bcastValid
);
  logic [NUM_ST-1:0] busy, sent, done;
  logic [NUM_ST-1:0] freeVec, readyVec, bcastOh, dispOh;

  assign freeVec  = ~busy;
  assign readyVec = busy & ~sent & opsReady;

  always_comb begin
    issueTag = '0;
    dispTag  = '0;
    bcastTag = '0;
    for (int i = NUM_ST - 1; i >= 0; i--) begin
      if (freeVec[i])  issueTag = TAG_W'(i + 1);
      if (readyVec[i]) dispTag  = TAG_W'(i + 1);
      if (done[i])     bcastTag = TAG_W'(i + 1);
    end
  end

  assign issueReady = |freeVec;
  assign execValid  = |readyVec;
  assign bcastValid = (|done) && !busHold;

  assign strb.issueEn = issueValid && issueReady;
  assign strb.dispEn  = execValid && execReady;
  assign strb.bcastEn = bcastValid;

  always_comb begin
    for (int i = 0; i < NUM_ST; i++) begin
      bcastOh[i] = strb.bcastEn && (bcastTag == TAG_W'(i + 1));
      dispOh[i]  = strb.dispEn  && (dispTag  == TAG_W'(i + 1));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= '0;
      sent <= '0;
      done <= '0;
    end else begin
      for (int i = 0; i < NUM_ST; i++) begin
        if (strb.issueEn && issueTag == TAG_W'(i + 1)) begin
          busy[i] <= 1'b1;
          sent[i] <= 1'b0;
          done[i] <= 1'b0;
        end
        if (dispOh[i]) sent[i] <= 1'b1;
        if (cmplValid && cmplTag == TAG_W'(i + 1)) done[i] <= 1'b1;
        if (bcastOh[i]) begin
          busy[i] <= 1'b0;
          sent[i] <= 1'b0;
          done[i] <= 1'b0;
        end
      end
    end
  end

  // R2: an accepted issue adds exactly one busy station
  p_issue_alloc_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.issueEn && !strb.bcastEn) |=> $countones(busy) == $countones($past(busy)) + 1);

  // R9: the broadcasting station is free on the next cycle
  p_bcast_frees_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.bcastEn |=> (busy & $past(bcastOh)) == '0);

  // R4: dispatch only picks a station whose operands are present
  p_disp_ready_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.dispEn |-> (dispOh & ~opsReady) == '0);

  // R6: a single grant, and finished stations keep waiting while the bus is held
  p_one_grant_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(bcastOh));
  p_hold_waits_r6: assert property (@(posedge clk) disable iff (!rstN)
    busHold |=> (done & $past(done)) == $past(done));
endmodule

// File: rtl/rspDatapath.sv
module rspDatapath import rspPkg::*; #(
  parameter int NUM_ST  = 4,
  parameter int NUM_REG = 8,
  parameter int DATA_W  = 16,
  parameter int OP_W    = 3,
  parameter int TAG_W   = 3,
  parameter int REG_W   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  rspStrobes_t       strb,
  input  logic [TAG_W-1:0]  issueTag,
  input  logic [TAG_W-1:0]  dispTag,
  input  logic [TAG_W-1:0]  bcastTag,
  input  logic [OP_W-1:0]   issueOp,
  input  logic [REG_W-1:0]  issueSrcA,
  input  logic [REG_W-1:0]  issueSrcB,
  input  logic [REG_W-1:0]  issueDest,
  input  logic              cmplValid,
  input  logic [TAG_W-1:0]  cmplTag,
  input  logic [DATA_W-1:0] cmplValue,
  input  logic [REG_W-1:0]  regQueryIdx,
  output logic [NUM_ST-1:0] opsReady,
  output logic [OP_W-1:0]   execOp,
  output logic [DATA_W-1:0] execOpA,
  output logic [DATA_W-1:0] execOpB,
  output logic [DATA_W-1:0] bcastValue,
  output logic [DATA_W-1:0] regQueryValue,
  output logic [TAG_W-1:0]  regQueryTag
);
  logic [DATA_W-1:0] vj [NUM_ST];
  logic [DATA_W-1:0] vk [NUM_ST];
  logic [TAG_W-1:0]  qj [NUM_ST];
  logic [TAG_W-1:0]  qk [NUM_ST];
  logic [OP_W-1:0]   opr [NUM_ST];
  logic [DATA_W-1:0] res [NUM_ST];
  logic [DATA_W-1:0] regVal [NUM_REG];
  logic [TAG_W-1:0]  regTag [NUM_REG];

  logic [TAG_W-1:0]  bcastIdx, dispIdx, tagA, tagB, newQj, newQk;
  logic [DATA_W-1:0] newVj, newVk;

  assign bcastIdx   = (bcastTag == '0) ? '0 : bcastTag - 1'b1;
  assign dispIdx    = (dispTag  == '0) ? '0 : dispTag  - 1'b1;
  assign bcastValue = res[bcastIdx];
  assign execOp     = opr[dispIdx];
  assign execOpA    = vj[dispIdx];
  assign execOpB    = vk[dispIdx];

  assign regQueryValue = regVal[regQueryIdx];
  assign regQueryTag   = regTag[regQueryIdx];

  // source lookup with same-cycle bus bypass (R3, R10)
  always_comb begin
    tagA  = regTag[issueSrcA];
    tagB  = regTag[issueSrcB];
    newVj = regVal[issueSrcA];
    newQj = '0;
    newVk = regVal[issueSrcB];
    newQk = '0;
    if (tagA != '0) begin
      if (strb.bcastEn && bcastTag == tagA) newVj = bcastValue;
      else newQj = tagA;
    end
    if (tagB != '0) begin
      if (strb.bcastEn && bcastTag == tagB) newVk = bcastValue;
      else newQk = tagB;
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_ST; i++) opsReady[i] = (qj[i] == '0) && (qk[i] == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_ST; i++) begin
        vj[i]  <= '0;
        vk[i]  <= '0;
        qj[i]  <= '0;
        qk[i]  <= '0;
        opr[i] <= '0;
        res[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_ST; i++) begin
        if (strb.issueEn && issueTag == TAG_W'(i + 1)) begin
          opr[i] <= issueOp;
          vj[i]  <= newVj;
          qj[i]  <= newQj;
          vk[i]  <= newVk;
          qk[i]  <= newQk;
        end else begin
          if (strb.bcastEn && qj[i] != '0 && qj[i] == bcastTag) begin
            vj[i] <= bcastValue;
            qj[i] <= '0;
          end
          if (strb.bcastEn && qk[i] != '0 && qk[i] == bcastTag) begin
            vk[i] <= bcastValue;
            qk[i] <= '0;
          end
        end
        if (cmplValid && cmplTag == TAG_W'(i + 1)) res[i] <= cmplValue;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < NUM_REG; r++) begin
        regVal[r] <= DATA_W'(r);
        regTag[r] <= '0;
      end
    end else begin
      for (int r = 0; r < NUM_REG; r++) begin
        if (strb.bcastEn && regTag[r] != '0 && regTag[r] == bcastTag) begin
          regVal[r] <= bcastValue;
          regTag[r] <= '0;
        end
        if (strb.issueEn && issueDest == REG_W'(r)) regTag[r] <= issueTag;
      end
    end
  end

  // R8 (and R10 for a source issued in the broadcast cycle): no operand still waits on a broadcast tag
  for (genvar g = 0; g < NUM_ST; g++) begin : gStChk
    p_wake_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
      strb.bcastEn |=> (qj[g] != $past(bcastTag)) && (qk[g] != $past(bcastTag)));
  end

  // R7: no register still names a tag after it has been broadcast
  for (genvar g = 0; g < NUM_REG; g++) begin : gRegChk
    p_reg_tag_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
      strb.bcastEn |=> regTag[g] != $past(bcastTag));
  end
endmodule

// File: rtl/resStationPool.sv
module resStationPool import rspPkg::*; #(
  parameter int NUM_ST  = 4,
  parameter int NUM_REG = 8,
  parameter int DATA_W  = 16,
  parameter int OP_W    = 3,
  localparam int TAG_W  = $clog2(NUM_ST + 1),
  localparam int REG_W  = $clog2(NUM_REG)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  output logic              issueReady,
  input  logic [OP_W-1:0]   issueOp,
  input  logic [REG_W-1:0]  issueSrcA,
  input  logic [REG_W-1:0]  issueSrcB,
  input  logic [REG_W-1:0]  issueDest,
  output logic              execValid,
  input  logic              execReady,
  output logic [TAG_W-1:0]  execTag,
  output logic [OP_W-1:0]   execOp,
  output logic [DATA_W-1:0] execOpA,
  output logic [DATA_W-1:0] execOpB,
  input  logic              cmplValid,
  input  logic [TAG_W-1:0]  cmplTag,
  input  logic [DATA_W-1:0] cmplValue,
  input  logic              busHold,
  output logic              bcastValid,
  output logic [TAG_W-1:0]  bcastTag,
  output logic [DATA_W-1:0] bcastValue,
  input  logic [REG_W-1:0]  regQueryIdx,
  output logic [DATA_W-1:0] regQueryValue,
  output logic [TAG_W-1:0]  regQueryTag
);
  rspStrobes_t       strb;
  logic [TAG_W-1:0]  issueTag;
  logic [NUM_ST-1:0] opsReady;

  rspControl #(.NUM_ST(NUM_ST), .TAG_W(TAG_W)) uCtrl (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .opsReady(opsReady),
    .execReady(execReady), .busHold(busHold), .cmplValid(cmplValid),
    .cmplTag(cmplTag), .strb(strb), .issueTag(issueTag), .dispTag(execTag),
    .bcastTag(bcastTag), .issueReady(issueReady), .execValid(execValid),
    .bcastValid(bcastValid)
  );

  rspDatapath #(.NUM_ST(NUM_ST), .NUM_REG(NUM_REG), .DATA_W(DATA_W),
                .OP_W(OP_W), .TAG_W(TAG_W), .REG_W(REG_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .issueTag(issueTag),
    .dispTag(execTag), .bcastTag(bcastTag), .issueOp(issueOp),
    .issueSrcA(issueSrcA), .issueSrcB(issueSrcB), .issueDest(issueDest),
    .cmplValid(cmplValid), .cmplTag(cmplTag), .cmplValue(cmplValue),
    .regQueryIdx(regQueryIdx), .opsReady(opsReady), .execOp(execOp),
    .execOpA(execOpA), .execOpB(execOpB), .bcastValue(bcastValue),
    .regQueryValue(regQueryValue), .regQueryTag(regQueryTag)
  );
endmodule

// File: tb/resStationPool_test.sv
`timescale 1ns/1ps
module resStationPool_test;
  localparam int NST = 4, NRG = 8, DW = 16, OW = 3, TW = 3, RW = 3;

  logic clk = 1'b0, rstN = 1'b0;
  logic issueValid = 0, execReady = 0, cmplValid = 0, busHold = 0;
  logic issueReady, execValid, bcastValid;
  logic [OW-1:0] issueOp = '0, execOp;
  logic [RW-1:0] issueSrcA = '0, issueSrcB = '0, issueDest = '0, regQueryIdx = '0;
  logic [TW-1:0] execTag, cmplTag = '0, bcastTag, regQueryTag;
  logic [DW-1:0] execOpA, execOpB, cmplValue = '0, bcastValue, regQueryValue;

  int nChk = 0, nBad = 0;
  logic [DW-1:0] shadow [NRG];

  always #2.5 clk = ~clk;

  resStationPool #(.NUM_ST(NST), .NUM_REG(NRG), .DATA_W(DW), .OP_W(OW)) uut (.*);

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] fu(input logic [OW-1:0] op, input logic [DW-1:0] a, input logic [DW-1:0] b);
    case (op)
      3'd0: fu = a + b;
      3'd1: fu = a - b;
      3'd2: fu = a ^ b;
      default: fu = (a << 1) + b + 16'h0100;
    endcase
  endfunction

  task automatic doReset();
    rstN = 0;
    repeat (2) @(negedge clk);
    rstN = 1;
    #1;
  endtask

  task automatic drvIssue(input int op, input int a, input int b, input int d);
    issueValid = 1; issueOp = OW'(op); issueSrcA = RW'(a); issueSrcB = RW'(b); issueDest = RW'(d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    @(negedge clk);
    doReset();
    // R1 reset state
    check(issueReady, 1, "R1 issueReady");
    check(execValid, 0, "R1 execValid");
    check(bcastValid, 0, "R1 bcastValid");
    for (int r = 0; r < NRG; r++) begin
      regQueryIdx = RW'(r); #0.1;
      check(regQueryValue, r, "R1 reg value");
      check(regQueryTag, 0, "R1 reg tag");
      shadow[r] = DW'(r);
    end

    // sweep: every opcode and every source pair, R2..R9
    for (int op = 0; op < 4; op++) begin
      for (int a = 0; a < NRG; a++) begin
        for (int b = 0; b < NRG; b++) begin
          automatic int d = (a + b + op) % NRG;
          automatic logic [DW-1:0] exp = fu(OW'(op), shadow[a], shadow[b]);
          @(negedge clk);
          drvIssue(op, a, b, d);
          regQueryIdx = RW'(d);
          #1 check(issueReady, 1, "R2 ready when free");
          @(negedge clk);
          issueValid = 0;
          #1;
          check(regQueryTag, 1, "R2 dest tag is station 1");
          check(execValid, 1, "R4 offer");
          check(execTag, 1, "R4 tag");
          check(execOp, op, "R4 op");
          check(execOpA, shadow[a], "R3 operand A");
          check(execOpB, shadow[b], "R3 operand B");
          execReady = 1;
          @(negedge clk);
          execReady = 0;
          #1 check(execValid, 0, "R4 no reoffer");
          cmplValid = 1; cmplTag = 3'd1; cmplValue = exp;
          @(negedge clk);
          cmplValid = 0;
          #1;
          check(bcastValid, 1, "R5 bcast valid");
          check(bcastTag, 1, "R6 bcast tag");
          check(bcastValue, exp, "R6 bcast value");
          @(negedge clk);
          #1;
          check(regQueryValue, exp, "R7 reg written");
          check(regQueryTag, 0, "R7 reg tag cleared");
          check(bcastValid, 0, "R9 bus idle");
          shadow[d] = exp;
        end
      end
    end

    // dependency chain, bus arbitration, WAW, bypass
    doReset();
    busHold = 1;
    drvIssue(0, 2, 3, 1);                      // st1: r1 = f(r2,r3)
    @(negedge clk); drvIssue(1, 1, 2, 4);      // st2 waits on tag 1
    #1; check(execValid, 1, "R4 st1 offered"); check(execTag, 1, "R4 st1 tag");
    check(execOpA, 2, "R3 A"); check(execOpB, 3, "R3 B");
    @(negedge clk); drvIssue(2, 5, 6, 1);      // st3 re-targets r1
    #1; check(execTag, 1, "R4 st2 waits");
    @(negedge clk); drvIssue(3, 1, 0, 7);      // st4 waits on tag 3
    regQueryIdx = 3'd1;
    #1; check(regQueryTag, 3, "R11 r1 renamed to 3");
    check(execTag, 1, "R4 lowest ready");
    execReady = 1;
    @(negedge clk); issueValid = 0;
    #1; check(issueReady, 0, "R2 full stalls");
    check(execValid, 1, "R4 st3 offered"); check(execTag, 3, "R4 st3 tag");
    check(execOpA, 5, "R4 st3 A"); check(execOpB, 6, "R4 st3 B");
    @(negedge clk); execReady = 0;
    #1; check(execValid, 0, "R4 waiting operands not offered");
    cmplValid = 1; cmplTag = 3'd3; cmplValue = 16'h3333;
    @(negedge clk); cmplTag = 3'd1; cmplValue = 16'h1111;
    #1; check(bcastValid, 0, "R6 held bus");
    @(negedge clk); cmplValid = 0; busHold = 0;
    #1; check(bcastValid, 1, "R6 release"); check(bcastTag, 1, "R6 lowest first");
    check(bcastValue, 16'h1111, "R6 value 1");
    @(negedge clk);
    #1; check(bcastTag, 3, "R6 retry next cycle"); check(bcastValue, 16'h3333, "R6 value 3");
    check(regQueryValue, 1, "R11 old producer ignored"); check(regQueryTag, 3, "R11 tag kept");
    check(issueReady, 1, "R9 station freed");
    check(execTag, 2, "R8 st2 woken"); check(execOpA, 16'h1111, "R8 st2 A");
    check(execOpB, 2, "R8 st2 B");
    drvIssue(0, 1, 1, 3);                      // st1 issued during tag-3 broadcast
    @(negedge clk); issueValid = 0;
    #1; check(regQueryValue, 16'h3333, "R7 r1 written"); check(regQueryTag, 0, "R7 r1 tag");
    check(execTag, 1, "R10 bypassed issue ready");
    check(execOpA, 16'h3333, "R10 A"); check(execOpB, 16'h3333, "R10 B");
    execReady = 1;
    @(negedge clk);
    #1; check(execTag, 2, "R4 next st2");
    @(negedge clk);
    #1; check(execTag, 4, "R8 st4 woken"); check(execOpA, 16'h3333, "R8 st4 A");
    check(execOpB, 0, "R8 st4 B");
    @(negedge clk); execReady = 0;
    #1; check(execValid, 0, "R4 all dispatched");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule